// File: doc/BRIEF.md
# RTC Time Read/Set Sequencer

This block converts whole-time transfers for a serial real-time-clock chip into the individual 4-bit register accesses that such a chip expects. It sits above a nibble register master and drives it through a request/done handshake. Each access names a 4-bit register address, a direction and, for writes, a data nibble. The sequencer waits for the master's done before it issues the next access.

Three commands are available. A read gathers seconds, minutes, hours, day, month, year and weekday into a 56-bit vector of packed BCD bytes. A set writes a 56-bit vector of the same layout into the clock. An init checks the clock's oscillator-stopped flag and, if the flag is set, restores a default date. Before a read or a set transfer, the block raises chip enable, forces 24-hour mode in the control register and polls the busy flag. It retries a bounded number of times and then gives up with an error. The host sees a one-cycle done pulse and a sticky error bit. Values cross the interface as BCD; binary conversion and century handling belong to the host.

Top module: `rtc_time_seq`

## Requirements
- R1: While reset is asserted and after it is released with no command, `ce_o`, `req_o`, `done_o` and `err_o` are all low.
- R2: A read or set begins with a handshake. The block writes 0x4 to the control register (address 0xE) and then reads it back. If bit 0 (busy) of the read-back value is 1, `ce_o` drops for exactly HALF_CYC cycles and the write/read pair repeats.
- R3: Every access is a one-cycle `req_o` made while `ce_o` is high. No new request is made before `acc_done_i` has answered the previous one.
- R4: On the (RETRY_LIMIT+1)-th busy read-back in a row, the command aborts. `err_o` sets and no register other than 0xE is accessed.
- R5: The vector is laid out as byte k of `time_o` / `time_i`, bits [8k+7:8k], with k = 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday. Units sit at the even address and tens at the next address: 0x0/0x1, 0x2/0x3, 0x4/0x5, 0x8/0x9, 0xA/0xB and 0xC/0xD. Weekday is the single nibble at 0x6.
- R6: A read accesses the registers in the order 0,1,2,3,4,5,8,9,A,B,C,D,6. Each `time_o` byte becomes {tens nibble, units nibble}, and the weekday tens nibble reads 0.
- R7: A set writes the low nibble and then the high nibble of each byte of `time_i`, in the field order of R6, ending with the low nibble of the weekday byte.
- R8: At the end of a command, `ce_o` stays low for HALF_CYC cycles. `done_o` then pulses high for exactly one cycle, still with `ce_o` low.
- R9: `err_o` stays set until the next command is accepted. Accepting that command clears it.
- R10: Init reads the control register. If bit 1 is 1, the block writes 0x0 to register 0x7 and 0x7 to register 0xE. It then polls busy (at most RETRY_LIMIT+1 reads) and runs a full set of the default time: day 01, month 01, all other fields 00. `time_o` then shows that default.
- R11: If bit 1 of the init read is 0, no other register is touched. Done pulses without error.
- R12: Commands that arrive while a command is running are ignored. When several commands arrive together, init wins over set, and set wins over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read_i | input | 1 | Start a time read (pulse) |
| cmd_set_i | input | 1 | Start a time set (pulse) |
| cmd_init_i | input | 1 | Start the oscillator-stop check (pulse) |
| time_i | input | 56 | BCD time to set, sampled when the set is accepted |
| time_o | output | 56 | BCD time read or set, valid at done |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky busy-timeout error |
| ce_o | output | 1 | Chip enable of the clock chip |
| req_o | output | 1 | Access request to the register master |
| we_o | output | 1 | Access is a write |
| addr_o | output | 4 | Register address |
| wdata_o | output | 4 | Write nibble |
| acc_done_i | input | 1 | Register master finished the access |
| rdata_i | input | 4 | Read nibble, valid with acc_done_i |

## Verification
Some rules hold on every cycle, and assertions check them there. Requests occur only under chip enable and are never back to back. Done is a single-cycle pulse. The retry counter never passes its limit. The error bit holds until a command is accepted. Other behaviour can only be shown by scenarios with the bench's register model: the register order, nibble packing, gap and tail lengths, the abort after exactly RETRY_LIMIT+1 busy reads with no time-register access, the init restore, and command priority and blocking.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  localparam int NFIELD  = 7;
  localparam int TIME_W  = 8 * NFIELD;
  localparam int NSTEP   = 2 * NFIELD - 1;
  localparam int STEP_W  = $clog2(NSTEP);
  localparam int FLD_W   = STEP_W - 1;

  // fields at index >= SKIP_FLD sit two addresses higher (weekday/interval slot)
  localparam int SKIP_FLD = 3;
  localparam int F_DAY    = 3;
  localparam int F_MON    = 4;

  localparam logic [3:0] A_WDAY = 4'h6;
  localparam logic [3:0] A_IVL  = 4'h7;
  localparam logic [3:0] A_CTL  = 4'hE;

  localparam logic [3:0] CTL_24H = 4'h4;
  localparam logic [3:0] CTL_ADJ = 4'h7;
  localparam logic [3:0] IVL_OFF = 4'h0;

  localparam int BUSY_BIT = 0;
  localparam int XSTP_BIT = 1;

  localparam logic [TIME_W-1:0] DFLT_TIME =
      (TIME_W'(8'h01) << (8 * F_DAY)) | (TIME_W'(8'h01) << (8 * F_MON));

  typedef enum logic [3:0] {
    S_IDLE, S_WCTL, S_RCTL, S_GAP, S_XFER,
    S_IRD, S_IWI, S_IWC, S_IPOLL, S_END
  } seq_state_t;

  typedef enum logic [1:0] { M_READ, M_SET, M_INIT } seq_mode_t;

  typedef enum logic [1:0] { B_HOLD, B_CLR, B_LOAD, B_DFLT } buf_op_t;

endpackage

// File: rtl/rtc_seq_map.sv
module rtc_seq_map
  import rtc_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output logic [3:0]        addr_o,
  output logic [FLD_W-1:0]  fld_o,
  output logic              hi_o
);

  logic [3:0] lin;

  always_comb begin
    fld_o = step_i[STEP_W-1:1];
    hi_o  = step_i[0];
    lin   = 4'({fld_o, hi_o});
    if (fld_o == FLD_W'(NFIELD - 1)) begin
      addr_o = A_WDAY;
    end else if (fld_o >= FLD_W'(SKIP_FLD)) begin
      addr_o = lin + 4'd2;
    end else begin
      addr_o = lin;
    end
  end

endmodule

// File: rtl/rtc_seq_timer.sv
module rtc_seq_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic fire_o
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)              cnt_d = CW'(CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire_o = (cnt_q == CW'(1));

  // expiry is a single cycle unless reloaded (R8, R2 window lengths)
  p_fire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !load_i |=> !fire_o);

endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
  import rtc_seq_pkg::*;
#(
  parameter int RETRY_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_read_i,
  input  logic              cmd_set_i,
  input  logic              cmd_init_i,
  input  logic              acc_done_i,
  input  logic [3:0]        rdata_i,
  input  logic [3:0]        step_addr_i,
  input  logic [3:0]        xfer_nib_i,
  input  logic              tmr_fire_i,
  output logic              tmr_load_o,
  output logic [STEP_W-1:0] step_o,
  output logic              cap_o,
  output buf_op_t           buf_op_o,
  output logic              ce_o,
  output logic              req_o,
  output logic              we_o,
  output logic [3:0]        addr_o,
  output logic [3:0]        wdata_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int TRY_W = $clog2(RETRY_LIMIT + 1) + 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

  seq_state_t        state_q, state_d;
  seq_mode_t         mode_q, mode_d;
  logic              pend_q, pend_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              acc;
  logic              start;

  assign start = (state_q == S_IDLE) && (cmd_read_i || cmd_set_i || cmd_init_i);

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    step_d     = step_q;
    tries_d    = tries_q;
    err_d      = err_q;
    done_d     = 1'b0;
    tmr_load_o = 1'b0;
    buf_op_o   = B_HOLD;
    acc        = 1'b0;
    we_o       = 1'b0;
    addr_o     = 4'h0;
    wdata_o    = 4'h0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_init_i) begin
          mode_d  = M_INIT;
          err_d   = 1'b0;
          tries_d = '0;
          state_d = S_IRD;
        end else if (cmd_set_i) begin
          mode_d   = M_SET;
          err_d    = 1'b0;
          tries_d  = '0;
          buf_op_o = B_LOAD;
          state_d  = S_WCTL;
        end else if (cmd_read_i) begin
          mode_d   = M_READ;
          err_d    = 1'b0;
          tries_d  = '0;
          buf_op_o = B_CLR;
          state_d  = S_WCTL;
        end
      end
      S_WCTL: begin
        acc     = 1'b1;
        we_o    = 1'b1;
        addr_o  = A_CTL;
        wdata_o = CTL_24H;
        if (acc_done_i) state_d = S_RCTL;
      end
      S_RCTL: begin
        acc    = 1'b1;
        addr_o = A_CTL;
        if (acc_done_i) begin
          if (!rdata_i[BUSY_BIT]) begin
            state_d = S_XFER;
            step_d  = '0;
          end else if (tries_q == TRY_W'(RETRY_LIMIT)) begin
            err_d      = 1'b1;
            state_d    = S_END;
            tmr_load_o = 1'b1;
          end else begin
            tries_d    = tries_q + 1'b1;
            state_d    = S_GAP;
            tmr_load_o = 1'b1;
          end
        end
      end
      S_GAP: begin
        if (tmr_fire_i) state_d = S_WCTL;
      end
      S_XFER: begin
        acc     = 1'b1;
        we_o    = (mode_q != M_READ);
        addr_o  = step_addr_i;
        wdata_o = xfer_nib_i;
        if (acc_done_i) begin
          if (step_q == LAST) begin
            state_d    = S_END;
            tmr_load_o = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      S_IRD: begin
        acc    = 1'b1;
        addr_o = A_CTL;
        if (acc_done_i) begin
          if (rdata_i[XSTP_BIT]) begin
            state_d = S_IWI;
          end else begin
            state_d    = S_END;
            tmr_load_o = 1'b1;
          end
        end
      end
      S_IWI: begin
        acc     = 1'b1;
        we_o    = 1'b1;
        addr_o  = A_IVL;
        wdata_o = IVL_OFF;
        if (acc_done_i) state_d = S_IWC;
      end
      S_IWC: begin
        acc     = 1'b1;
        we_o    = 1'b1;
        addr_o  = A_CTL;
        wdata_o = CTL_ADJ;
        if (acc_done_i) begin
          state_d = S_IPOLL;
          tries_d = '0;
        end
      end
      S_IPOLL: begin
        acc    = 1'b1;
        addr_o = A_CTL;
        if (acc_done_i) begin
          if (!rdata_i[BUSY_BIT] || tries_q == TRY_W'(RETRY_LIMIT)) begin
            mode_d   = M_SET;
            buf_op_o = B_DFLT;
            tries_d  = '0;
            state_d  = S_WCTL;
          end else begin
            tries_d = tries_q + 1'b1;
          end
        end
      end
      S_END: begin
        if (tmr_fire_i) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign req_o  = acc && !pend_q;
  assign pend_d = acc_done_i ? 1'b0 : (req_o ? 1'b1 : pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= M_READ;
      pend_q  <= 1'b0;
      step_q  <= '0;
      tries_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      step_q  <= step_d;
      tries_q <= tries_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign ce_o = (state_q == S_WCTL) || (state_q == S_RCTL) || (state_q == S_XFER) ||
                (state_q == S_IRD)  || (state_q == S_IWI)  || (state_q == S_IWC)  ||
                (state_q == S_IPOLL);
  assign step_o = step_q;
  assign cap_o  = (state_q == S_XFER) && acc_done_i && (mode_q == M_READ);
  assign done_o = done_q;
  assign err_o  = err_q;

  p_req_under_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ce_o);

  p_req_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_retry_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(RETRY_LIMIT));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !start |=> err_o);

endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq
  import rtc_seq_pkg::*;
#(
  parameter int RETRY_LIMIT = 100,
  parameter int HALF_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_read_i,
  input  logic              cmd_set_i,
  input  logic              cmd_init_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] time_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ce_o,
  output logic              req_o,
  output logic              we_o,
  output logic [3:0]        addr_o,
  output logic [3:0]        wdata_o,
  input  logic              acc_done_i,
  input  logic [3:0]        rdata_i
);

  localparam int NIB_W = FLD_W + 3;

  logic [STEP_W-1:0] step;
  logic [3:0]        step_addr;
  logic [FLD_W-1:0]  fld;
  logic              hi;
  logic [NIB_W-1:0]  nib_base;
  logic [3:0]        xfer_nib;
  logic              cap;
  logic              tmr_load;
  logic              tmr_fire;
  buf_op_t           buf_op;
  logic [TIME_W-1:0] tbuf_q, tbuf_d;

  rtc_seq_map u_map (
    .step_i (step),
    .addr_o (step_addr),
    .fld_o  (fld),
    .hi_o   (hi)
  );

  rtc_seq_timer #(.CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .fire_o (tmr_fire)
  );

  rtc_seq_fsm #(.RETRY_LIMIT(RETRY_LIMIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_read_i  (cmd_read_i),
    .cmd_set_i   (cmd_set_i),
    .cmd_init_i  (cmd_init_i),
    .acc_done_i  (acc_done_i),
    .rdata_i     (rdata_i),
    .step_addr_i (step_addr),
    .xfer_nib_i  (xfer_nib),
    .tmr_fire_i  (tmr_fire),
    .tmr_load_o  (tmr_load),
    .step_o      (step),
    .cap_o       (cap),
    .buf_op_o    (buf_op),
    .ce_o        (ce_o),
    .req_o       (req_o),
    .we_o        (we_o),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  // nibble offset of the current step inside the time vector
  assign nib_base = {fld, hi, 2'b00};
  assign xfer_nib = tbuf_q[nib_base +: 4];

  always_comb begin
    tbuf_d = tbuf_q;
    unique case (buf_op)
      B_CLR:  tbuf_d = '0;
      B_LOAD: tbuf_d = time_i;
      B_DFLT: tbuf_d = DFLT_TIME;
      default: begin
        if (cap) tbuf_d[nib_base +: 4] = rdata_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbuf_q <= '0;
    else        tbuf_q <= tbuf_d;
  end

  assign time_o = tbuf_q;

endmodule

// File: tb/rtc_time_seq_tb.sv
module rtc_time_seq_tb;

  localparam int LIM  = 100;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_read, cmd_set, cmd_init;
  logic [55:0] time_in;
  logic [55:0] time_out;
  logic        done, err, ce, req, we;
  logic [3:0]  addr, wdata;
  logic        acc_done;
  logic [3:0]  rdata;

  always #5 clk = ~clk;

  rtc_time_seq #(.RETRY_LIMIT(LIM), .HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_read_i(cmd_read), .cmd_set_i(cmd_set), .cmd_init_i(cmd_init),
    .time_i(time_in), .time_o(time_out), .done_o(done), .err_o(err),
    .ce_o(ce), .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .acc_done_i(acc_done), .rdata_i(rdata)
  );

  // ---------------- register master + chip model ----------------
  logic [3:0] regs [16];
  int         busy_left;
  logic       xstp;
  logic [3:0] ctl_last;
  int         e_reads, time_acc, time_wr, ce_viol;
  logic [3:0] wlog [64];
  int         wlog_n;
  int         mcnt;
  logic [3:0] m_addr, m_wd;
  logic       m_we;
  int         low_run, last_gap;
  int         checks, errors;

  function automatic bit is_time(input logic [3:0] a);
    return (a <= 4'h6) || (a >= 4'h8 && a <= 4'hD);
  endfunction

  function automatic logic [3:0] exp_addr(input int k);
    if (k == 12) return 4'h6;
    if (k / 2 < 3) return 4'(k);
    return 4'(k + 2);
  endfunction

  always @(posedge clk) begin
    acc_done <= 1'b0;
    if (!rst_n) begin
      mcnt = 0;
    end else if (req) begin
      m_addr <= addr; m_we <= we; m_wd <= wdata;
      mcnt = 2;
      if (!ce) ce_viol++;
    end else if (mcnt != 0) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) begin
        acc_done <= 1'b1;
        if (m_we) begin
          regs[m_addr] = m_wd;
          if (is_time(m_addr)) begin time_acc++; time_wr++; end
          if (wlog_n < 64) begin wlog[wlog_n] = m_addr; wlog_n++; end
          if (m_addr == 4'hE) begin
            ctl_last = m_wd;
            if (m_wd == 4'h7) xstp = 1'b0;
          end
        end else if (m_addr == 4'hE) begin
          rdata <= {1'b0, ctl_last[2], xstp, busy_left != 0};
          e_reads++;
          if (busy_left > 0) busy_left--;
        end else begin
          rdata <= regs[m_addr];
          if (is_time(m_addr)) time_acc++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!ce) low_run++;
    else begin
      if (low_run > 0) last_gap = low_run;
      low_run = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    e_reads = 0; time_acc = 0; time_wr = 0; wlog_n = 0;
  endtask

  task automatic issue(input bit r, input bit s, input bit i);
    tick();
    cmd_read = r; cmd_set = s; cmd_init = i;
    tick();
    cmd_read = 0; cmd_set = 0; cmd_init = 0;
  endtask

  int end_low;
  task automatic wait_done(output bit ok);
    ok = 0;
    for (int n = 0; n < 20000; n++) begin
      if (done) begin ok = 1; end_low = low_run; break; end
      tick();
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    bit ok;
    logic [55:0] exp_t;
    checks = 0; errors = 0; ce_viol = 0; low_run = 0; last_gap = 0;
    busy_left = 0; xstp = 0; ctl_last = 0;
    for (int a = 0; a < 16; a++) regs[a] = 4'(a);
    clear_log();
    cmd_read = 0; cmd_set = 0; cmd_init = 0; time_in = '0;
    rst_n = 0;
    repeat (3) tick();
    chk(!ce && !req && !done && !err, "R1 reset outputs", {ce, req, done, err}, 0);
    rst_n = 1;
    repeat (3) tick();
    chk(!ce && !req && !done && !err, "R1 idle outputs", {ce, req, done, err}, 0);

    // read sweep (R5, R6, R2)
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 16; a++) if (a != 14) regs[a] = 4'((a * 7 + p * 3 + 1) & 15);
      clear_log();
      issue(1, 0, 0);
      wait_done(ok);
      chk(ok, "R6 read done", ok, 1);
      exp_t = '0;
      for (int k = 0; k < 6; k++) begin
        logic [3:0] ua;
        ua = exp_addr(2 * k);
        exp_t[8*k +: 8] = {regs[ua + 4'd1], regs[ua]};
      end
      exp_t[55:48] = {4'h0, regs[6]};
      chk(time_out == exp_t, "R5 R6 read packing", time_out, exp_t);
      chk(time_acc == 13 && e_reads == 1, "R6 read access count", time_acc, 13);
      chk(ctl_last == 4'h4 && wlog_n == 1 && wlog[0] == 4'hE, "R2 control write 0x4", ctl_last, 4);
      chk(end_low == HALF + 1, "R8 tail ce-low length", end_low, HALF + 1);
      tick();
      chk(!done, "R8 done single cycle", done, 0);
    end

    // set sweep (R7)
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 7; k++) time_in[8*k +: 8] = 8'((k * 17 + p * 35 + 9) & 255);
      regs[7] = 4'h9;
      clear_log();
      issue(0, 1, 0);
      wait_done(ok);
      for (int k = 0; k < 13; k++) begin
        logic [3:0] ea;
        logic [3:0] ev;
        ea = exp_addr(k);
        ev = time_in[8*(k/2) + 4*(k%2) +: 4];
        chk(wlog[1+k] == ea, "R7 write order", wlog[1+k], ea);
        chk(regs[ea] == ev, "R7 written nibble", regs[ea], ev);
      end
      chk(wlog_n == 14 && regs[7] == 4'h9, "R7 write count", wlog_n, 14);
      chk(time_out == time_in, "R7 time_o holds set value", time_out, time_in);
    end

    // busy retries (R2)
    busy_left = 3;
    clear_log();
    issue(1, 0, 0);
    wait_done(ok);
    chk(ok && !err, "R2 retry success", err, 0);
    chk(e_reads == 4, "R2 busy reads", e_reads, 4);
    chk(last_gap == HALF, "R2 ce gap length", last_gap, HALF);
    chk(time_acc == 13, "R2 transfer after retries", time_acc, 13);

    // busy timeout (R4, R9)
    busy_left = 1000;
    clear_log();
    issue(0, 1, 0);
    wait_done(ok);
    chk(ok && err, "R4 timeout error", err, 1);
    chk(e_reads == LIM + 1, "R4 failed check count", e_reads, LIM + 1);
    chk(time_acc == 0, "R4 no time access", time_acc, 0);
    repeat (10) tick();
    chk(err, "R9 error sticky", err, 1);
    busy_left = 0;
    issue(1, 0, 0);
    chk(!err, "R9 error cleared on accept", err, 1'b0);
    wait_done(ok);
    chk(!err, "R9 clean after retry", err, 0);

    // init, stopped oscillator (R10)
    for (int a = 0; a < 16; a++) if (a != 14) regs[a] = 4'hB;
    xstp = 1; busy_left = 2;
    clear_log();
    issue(0, 0, 1);
    wait_done(ok);
    chk(ok && !err, "R10 init done", err, 0);
    chk(wlog[0] == 4'h7 && wlog[1] == 4'hE && regs[7] == 4'h0, "R10 interval cleared", regs[7], 0);
    chk(!xstp && ctl_last == 4'h4, "R10 control sequence", ctl_last, 4);
    exp_t = 56'h00000101000000;
    chk(time_out == exp_t, "R10 default time_o", time_out, exp_t);
    for (int a = 0; a < 14; a++) if (a != 7) begin
      logic [3:0] ev;
      ev = (a == 8 || a == 10) ? 4'h1 : 4'h0;
      chk(regs[a] == ev, "R10 default register", regs[a], ev);
    end

    // init, oscillator fine (R11)
    clear_log();
    regs[7] = 4'h5;
    issue(0, 0, 1);
    wait_done(ok);
    chk(ok && !err && wlog_n == 0 && time_acc == 0 && regs[7] == 4'h5, "R11 init no-op", wlog_n, 0);
    chk(e_reads == 1, "R11 single control read", e_reads, 1);

    // ignored command and priority (R12)
    clear_log();
    issue(1, 0, 0);
    repeat (4) tick();
    time_in = 56'h12345678901234;
    issue(0, 1, 1);
    wait_done(ok);
    chk(time_wr == 0 && time_acc == 13, "R12 command while busy ignored", time_wr, 0);
    repeat (3) tick();
    chk(!ce && !done, "R12 nothing pending", ce, 0);
    clear_log();
    issue(1, 1, 0);
    wait_done(ok);
    chk(time_wr == 13, "R12 set wins over read", time_wr, 13);
    clear_log();
    issue(1, 1, 1);
    wait_done(ok);
    chk(time_wr == 0 && e_reads == 1, "R12 init wins", e_reads, 1);

    chk(ce_viol == 0, "R3 requests under ce", ce_viol, 0);
    finish_run();
  end

endmodule